// File: doc/BRIEF.md
# Cache Range Maintenance Sequencer

This engine applies one cache maintenance action (invalidate, flush or lock) to every cache line that a byte range touches, so that software issues one request instead of a loop of per-line writes. A request carries a start address, a byte count and an action code. It is taken over a valid/ready handshake: `req_ready` is high only while the engine is idle. A request offered while the engine is busy simply waits, because the requester must hold `req_valid` and the fields stable until a cycle in which `req_ready` is high.

After it takes a request, the engine checks it. A request with a zero size, a size above the cache capacity, or the reserved action code ends at once with an error and sends no line command. A valid request rounds the start down to a line boundary and works out the last byte address with one extra bit of width. It then steps line by line. For each line it pulses a one-cycle command to the cache and waits a fixed settling time. It then reads the cache status. For flush and invalidate it waits until the cache's busy flag is low. For lock it reads a per-line success flag and aborts on the first failure. At the end it pulses `done` for one cycle, together with `error` if the request failed.

Top module: `cache_range_seq`

## Requirements
- R1: `req_ready` is high exactly when the engine is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `busy` is high from the cycle after acceptance through the cycle in which `done` pulses, and `done` is high for exactly one cycle per request.
- R2: A request with `req_size` equal to 0, or greater than CAPACITY, completes with `done` and `error` high and produces no `cmd_valid` pulse. A size equal to CAPACITY is accepted.
- R3: The action code is 0 for invalidate, 1 for flush and 2 for lock. Code 3 is reserved and is rejected in the same way as in R2.
- R4: The first command address is `req_addr` with its low log2(LINE_BYTES) bits cleared.
- R5: Each later command address is the previous one plus LINE_BYTES. Commands continue while the address is at or below `req_addr + req_size - 1`, so exactly the lines the range touches are commanded, in ascending order.
- R6: A range whose last byte is the top of the address space (all ones) issues its lines and then completes, without wrapping to address 0.
- R7: `cmd_op` carries the action code of the request on every command.
- R8: After each command, at least SETTLE cycles pass before status is sampled. Two consecutive commands are therefore at least SETTLE+2 cycles apart.
- R9: For flush and invalidate, no further command and no completion happens while `cache_busy` is high when status is sampled. The engine advances only once `cache_busy` is low.
- R10: For lock, if `cache_ok` is low when status is sampled, the request ends in the next cycle with `done` and `error` high and no further command. If `cache_ok` is high, the engine moves to the next line.
- R11: `error` is high only together with `done`, and it is low when every line of a valid request completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_addr | input | ADDR_W | Start byte address |
| req_size | input | ADDR_W | Range length in bytes |
| req_op | input | 2 | Action: 0 invalidate, 1 flush, 2 lock, 3 reserved |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Request failed, valid with done |
| cmd_valid | output | 1 | One-cycle per-line command pulse to the cache |
| cmd_addr | output | ADDR_W | Line address of the command |
| cmd_op | output | 2 | Action code of the command |
| cache_busy | input | 1 | Cache still executing a flush or invalidate |
| cache_ok | input | 1 | Most recent lock command succeeded |

## Verification
The assertions assume that the cache raises `cache_busy` only in response to a flush or invalidate command. They also assume that it holds `cache_ok` steady from one command until the next, so that whatever value is sampled belongs to the latest line. The bench responder follows these rules. After a flush or invalidate command it holds `cache_busy` high for a fixed number of cycles, which is longer than the settling time, so that the wait path is exercised. It keeps `cache_busy` low for lock commands and drives `cache_ok` from the address of the last command it saw. Requests are presented only while `req_ready` is high and with stable fields, which matches the handshake the block expects.

// File: rtl/crs_pkg.sv
package crs_pkg;
  typedef enum logic [1:0] {
    ACT_INVAL = 2'd0,
    ACT_FLUSH = 2'd1,
    ACT_LOCK  = 2'd2,
    ACT_RSVD  = 2'd3
  } act_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_SETTLE,
    ST_CHECK,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/crs_range.sv
module crs_range #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int CAPACITY   = 1024
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] size,
  input  logic [1:0]        op,
  output logic              bad,
  output logic [ADDR_W:0]   first_addr,
  output logic [ADDR_W:0]   last_addr
);
  import crs_pkg::*;
  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam logic [ADDR_W:0] CAP_W = (ADDR_W+1)'(CAPACITY);

  if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || LINE_BYTES < 2) begin : g_line_chk
    $error("LINE_BYTES must be a power of two of at least 2");
  end
  if ((CAPACITY & (CAPACITY - 1)) != 0 || CAPACITY < LINE_BYTES) begin : g_cap_chk
    $error("CAPACITY must be a power of two no smaller than LINE_BYTES");
  end

  logic [ADDR_W:0] addr_x, size_x;

  always_comb begin
    addr_x     = {1'b0, addr};
    size_x     = {1'b0, size};
    bad        = (size == '0) || (size_x > CAP_W) || (op == ACT_RSVD);
    first_addr = {addr_x[ADDR_W:OFS_W], {OFS_W{1'b0}}};
    last_addr  = addr_x + size_x - 1'b1;
  end
endmodule

// File: rtl/crs_settle.sv
module crs_settle #(
  parameter int SETTLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire
);
  localparam int CW = $clog2(SETTLE + 1);

  if (SETTLE < 1) begin : g_settle_chk
    $error("SETTLE must be at least 1");
  end

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(SETTLE);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == CW'(1));
endmodule

// File: rtl/cache_range_seq.sv
module cache_range_seq #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int CAPACITY   = 1024,
  parameter int SETTLE     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_size,
  input  logic [1:0]        req_op,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [1:0]        cmd_op,
  input  logic              cache_busy,
  input  logic              cache_ok
);
  import crs_pkg::*;
  localparam int AW1   = ADDR_W + 1;
  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam int GAP_W = 16;

  seq_state_t     st;
  logic [AW1-1:0] cur_a, last_a, next_a;
  logic [1:0]     op_q;
  logic           err_q;
  logic           bad;
  logic [AW1-1:0] first_c, last_c;
  logic           settle_exp;
  logic           more;
  logic           take;

  crs_range #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .CAPACITY(CAPACITY)
  ) u_range (
    .addr(req_addr), .size(req_size), .op(req_op),
    .bad(bad), .first_addr(first_c), .last_addr(last_c)
  );

  crs_settle #(.SETTLE(SETTLE)) u_settle (
    .clk(clk), .rst_n(rst_n), .start(st == ST_ISSUE), .expire(settle_exp)
  );

  assign take   = req_valid && req_ready;
  assign next_a = cur_a + AW1'(LINE_BYTES);
  assign more   = (next_a <= last_a);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cur_a  <= '0;
      last_a <= '0;
      op_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (take) begin
          cur_a  <= first_c;
          last_a <= last_c;
          op_q   <= req_op;
          err_q  <= bad;
          st     <= bad ? ST_DONE : ST_ISSUE;
        end
        ST_ISSUE:  st <= ST_SETTLE;
        ST_SETTLE: if (settle_exp) st <= ST_CHECK;
        ST_CHECK: begin
          if (op_q == ACT_LOCK && !cache_ok) begin
            err_q <= 1'b1;
            st    <= ST_DONE;
          end else if (op_q != ACT_LOCK && cache_busy) begin
            st <= ST_CHECK;
          end else if (more) begin
            cur_a <= next_a;
            st    <= ST_ISSUE;
          end else begin
            st <= ST_DONE;
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign busy      = (st != ST_IDLE);
  assign done      = (st == ST_DONE);
  assign error     = done && err_q;
  assign cmd_valid = (st == ST_ISSUE);
  assign cmd_addr  = cur_a[ADDR_W-1:0];
  assign cmd_op    = op_q;

  // Cycles since the previous command, for the spacing check.
  logic [GAP_W-1:0] gap;
  logic             seen_cmd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap      <= '0;
      seen_cmd <= 1'b0;
    end else if (cmd_valid) begin
      gap      <= GAP_W'(1);
      seen_cmd <= 1'b1;
    end else if (gap != '1) begin
      gap <= gap + 1'b1;
    end
  end

  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy);
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && bad) |=> (done && error && !cmd_valid));
  assert_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_addr[OFS_W-1:0] == '0));
  assert_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cur_a <= last_a));
  assert_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && seen_cmd) |-> (gap >= GAP_W'(SETTLE + 2)));
  assert_wait_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CHECK && op_q != ACT_LOCK && cache_busy) |=> (!cmd_valid && !done));
  assert_lock_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CHECK && op_q == ACT_LOCK && !cache_ok) |=> (done && error && !cmd_valid));
  assert_err_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> busy);
endmodule

// File: tb/test_cache_range_seq.sv
`timescale 1ns/100ps
module test_cache_range_seq;
  localparam int AW = 32, LINE = 16, CAP = 1024, SETTLE = 3, BUSY_LEN = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0, req_size = '0;
  logic [1:0] req_op = '0;
  logic busy, done, error, cmd_valid;
  logic [AW-1:0] cmd_addr;
  logic [1:0] cmd_op;
  logic cache_busy = 1'b0, cache_ok = 1'b1;

  always #2.5 clk = ~clk;

  cache_range_seq #(.ADDR_W(AW), .LINE_BYTES(LINE), .CAPACITY(CAP), .SETTLE(SETTLE))
  i_cache_range_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_op(req_op),
    .busy(busy), .done(done), .error(error), .cmd_valid(cmd_valid),
    .cmd_addr(cmd_addr), .cmd_op(cmd_op), .cache_busy(cache_busy), .cache_ok(cache_ok)
  );

  int checks = 0, errors = 0;
  int cycle = 0, last_cmd_cycle = -1, done_cnt = 0;
  string tag = "R1";
  logic [AW-1:0] exp_addr[$];
  logic [1:0]    exp_op[$];
  logic          exp_err[$];
  bit            fail_en = 0;
  logic [AW-1:0] fail_at = '0;
  int            min_gap = SETTLE + 2;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // Responder: busy after flush/invalidate, ok flag from last commanded address.
  int bcnt = 0;
  always @(negedge clk) begin
    cycle++;
    if (bcnt > 0) begin
      bcnt--;
      if (bcnt == 0) cache_busy = 1'b0;
    end
    if (cmd_valid) begin
      if (cmd_op != 2'd2) begin
        bcnt = BUSY_LEN;
        cache_busy = 1'b1;
      end
      cache_ok = !(fail_en && cmd_addr == fail_at);
    end
  end

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      if (exp_addr.size() == 0) begin
        chk({tag, " unexpected command"}, {32'd0, cmd_addr}, 64'hDEAD);
      end else begin
        chk({tag, " command address (R4 R5)"}, {32'd0, cmd_addr}, {32'd0, exp_addr.pop_front()});
        chk("R7 command op", {62'd0, cmd_op}, {62'd0, exp_op.pop_front()});
      end
      if (last_cmd_cycle >= 0)
        chk("R8 R9 command spacing", {63'd0, (cycle - last_cmd_cycle) >= min_gap}, 64'd1);
      last_cmd_cycle = cycle;
    end
    if (rst_n && done) begin
      chk({tag, " error flag (R11)"}, {63'd0, error}, {63'd0, exp_err.pop_front()});
      chk({tag, " all lines issued"}, exp_addr.size(), 0);
      chk("R1 busy with done", {63'd0, busy}, 64'd1);
      done_cnt++;
    end
  end

  task automatic run(input string t, input logic [AW-1:0] a, input logic [AW-1:0] s,
                     input logic [1:0] op, input bit fe, input logic [AW-1:0] fa);
    longint unsigned last, ln;
    bit bad, err;
    int prev;
    tag = t; fail_en = fe; fail_at = fa;
    min_gap = (op == 2'd2) ? SETTLE + 2 : BUSY_LEN + 1;
    last_cmd_cycle = -1;
    bad = (s == 0) || (s > CAP) || (op == 2'd3);
    err = bad;
    if (!bad) begin
      last = longint'(a) + longint'(s) - 1;
      ln = longint'(a) & ~longint'(LINE - 1);
      while (ln <= last) begin
        exp_addr.push_back(ln[AW-1:0]);
        exp_op.push_back(op);
        if (fe && ln[AW-1:0] == fa) begin err = 1; break; end
        ln += LINE;
      end
    end
    exp_err.push_back(err);
    prev = done_cnt;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = s; req_op = op;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 busy and not ready after accept", {62'd0, busy, req_ready}, 64'd2);
    while (done_cnt == prev) @(negedge clk);
    @(negedge clk);
    chk("R1 idle after done", {62'd0, busy, req_ready}, 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", {60'd0, req_ready, busy, done, cmd_valid}, 64'b1000);
    rst_n = 1'b1;
    run("R5 invalidate unaligned", 32'h0000_1004, 32'd40, 2'd0, 0, '0);
    run("R9 flush with busy", 32'h0000_2000, 32'd48, 2'd1, 0, '0);
    run("R10 lock success", 32'h0000_300F, 32'd2, 2'd2, 0, '0);
    run("R10 lock fail mid", 32'h0000_4000, 32'd64, 2'd2, 1, 32'h0000_4010);
    run("R2 size zero", 32'h0000_5000, 32'd0, 2'd0, 0, '0);
    run("R2 size over capacity", 32'h0000_5000, CAP + 1, 2'd1, 0, '0);
    run("R2 size equal capacity", 32'h0000_6008, CAP, 2'd2, 0, '0);
    run("R3 reserved op", 32'h0000_7000, 32'd16, 2'd3, 0, '0);
    run("R6 top of space", 32'hFFFF_FFE8, 32'd24, 2'd0, 0, '0);
    run("R6 last byte only", 32'hFFFF_FFFF, 32'd1, 2'd2, 0, '0);
    run("R4 single byte", 32'h0000_800B, 32'd1, 2'd1, 0, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule